// File: doc/BRIEF.md
# Flash Erase Command Sequence Decoder

This block sits on the write side of a parallel NOR-flash-style bus. It watches the address, data and write-enable lines and picks out the two six-write erase commands. The chip-wide form launches an erase of every sector at once. The per-sector form opens a retriggerable acceptance window. While that window is open, further single writes carrying the sector command and a sector address add sectors to a bitmap, and the unlock cycles do not have to be repeated.

When the window runs out with no new sector write, the block sends a one-cycle start pulse to an external erase engine. The pulse carries the bitmap of queued sectors. A status flag shows whether the window is still open or has expired. Any other write inside the window throws the queued sectors away and returns the block to array-read mode. The block does not model the array, the erase algorithm or analog timing.

Top module: `erase_seq_decoder`

## Requirements
- R1: After reset, `erase_start` is 0, `erase_mask` is all zeros, `timer_expired` is 0 and `read_mode` is 1.
- R2: The six writes 0x555/0xAA, 0x2AA/0x55, 0x555/0x80, 0x555/0xAA, 0x2AA/0x55, 0x555/0x10 (full address, then data) make `erase_start` 1 in the cycle after the sixth write. At the same time `erase_mask` is all ones, `timer_expired` is 1 and `read_mode` stays 1. No window is opened.
- R3: The same first five writes followed by data 0x30 at any address open the window and queue the sector given by the top SECT_W address bits as mask bit index. From the next cycle `read_mode` is 0 and `timer_expired` is 0.
- R4: `erase_start` rises exactly WINDOW_CYC cycles after the last accepted sector write. `erase_mask` then holds every queued sector, `read_mode` returns to 1, and `timer_expired` is 1 and stays 1 until a new window opens.
- R5: Inside the window, a single write with data 0x30 adds the sector from its address to the queue, in any order, and restarts the full window length.
- R6: Inside the window, a write with data 0xB0 is ignored. The queue is unchanged and the window is not restarted.
- R7: Inside the window, a write with any data other than 0x30 or 0xB0 clears the queue and returns to read mode. No start is issued.
- R8: A write that does not match the expected address and data in any of the first five cycles sends the decoder back to cycle one. A sequence then needs all six writes again.
- R9: A sector write that lands on the clock edge where the window expires is rejected. The start goes out with the earlier mask only.
- R10: Reset during an open window discards the queue with no start, and restores the R1 state.
- R11: `erase_start` is high for one cycle per launch. `erase_mask` holds its value until the next launch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Bus write strobe; one write per cycle it is high |
| wr_addr | input | ADDR_W | Write address; top SECT_W bits select the sector |
| wr_data | input | 8 | Write data (command code) |
| erase_start | output | 1 | One-cycle launch pulse to the erase engine |
| erase_mask | output | NUM_SECT | Sectors to erase, valid with the pulse and held afterwards |
| timer_expired | output | 1 | 0 while the window is open, 1 once it has expired or a chip erase launched |
| read_mode | output | 1 | 1 unless a sector window is open |

## Verification
The chip-wide sequence and the per-sector sequence share their first five writes. Running both shows that the sixth write alone chooses between an immediate all-ones launch and an open window. Single-sector, multi-sector and late-added sectors are each timed by counting cycles to the start pulse, which separates restarting the window from merely extending the queue. Suspend, foreign-command, corrupted-unlock and reset stimuli each hit the window or the matcher at a different point. Writes placed one cycle before and exactly on the expiry edge pin down the acceptance boundary.

// File: rtl/erase_seq_pkg.sv
package erase_seq_pkg;

  localparam logic [11:0] CMD_ADDR_HI = 12'h555;
  localparam logic [11:0] CMD_ADDR_LO = 12'h2AA;
  localparam logic [7:0]  CODE_KEY_A  = 8'hAA;
  localparam logic [7:0]  CODE_KEY_B  = 8'h55;
  localparam logic [7:0]  CODE_ARM    = 8'h80;
  localparam logic [7:0]  CODE_CHIP   = 8'h10;
  localparam logic [7:0]  CODE_SECTOR = 8'h30;
  localparam logic [7:0]  CODE_PAUSE  = 8'hB0;

  localparam int unsigned LAST_STEP = 5;

  typedef enum logic {
    MODE_READ   = 1'b0,
    MODE_WINDOW = 1'b1
  } dec_mode_t;

  // Expected {address, data} for command step 0..4 of the erase preamble.
  function automatic logic [19:0] step_code(input logic [2:0] step);
    case (step)
      3'd0:    step_code = {CMD_ADDR_HI, CODE_KEY_A};
      3'd1:    step_code = {CMD_ADDR_LO, CODE_KEY_B};
      3'd2:    step_code = {CMD_ADDR_HI, CODE_ARM};
      3'd3:    step_code = {CMD_ADDR_HI, CODE_KEY_A};
      3'd4:    step_code = {CMD_ADDR_LO, CODE_KEY_B};
      default: step_code = 20'h0;
    endcase
  endfunction

  // Window count value loaded on each accepted sector write.
  function automatic int unsigned window_reload(input int unsigned cycles);
    window_reload = cycles - 1;
  endfunction

endpackage

// File: rtl/erase_cycle_matcher.sv
module erase_cycle_matcher
  import erase_seq_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int SECT_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hold,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  output logic              chip_hit,
  output logic              sect_hit,
  output logic [SECT_W-1:0] sect_idx
);

  logic [2:0]  step_q;
  logic [19:0] want;
  logic        pre_ok;
  logic        at_last;
  logic        addr_hi_ok;

  always_comb begin
    want       = step_code(step_q);
    pre_ok     = (wr_addr == ADDR_W'(want[19:8])) && (wr_data == want[7:0]);
    at_last    = (step_q == 3'(LAST_STEP));
    addr_hi_ok = (wr_addr == ADDR_W'(CMD_ADDR_HI));
    chip_hit   = wr_en && !hold && at_last && addr_hi_ok && (wr_data == CODE_CHIP);
    sect_hit   = wr_en && !hold && at_last && (wr_data == CODE_SECTOR);
    sect_idx   = wr_addr[ADDR_W-1 -: SECT_W];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      step_q <= 3'd0;
    end else if (hold) begin
      step_q <= 3'd0;
    end else if (wr_en) begin
      if (!at_last && pre_ok) step_q <= step_q + 3'd1;
      else                    step_q <= 3'd0;
    end
  end

endmodule

// File: rtl/erase_sector_queue.sv
module erase_sector_queue #(
  parameter int NUM_SECT = 8,
  parameter int SECT_W   = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                set_en,
  input  logic [SECT_W-1:0]   set_idx,
  input  logic                clear,
  output logic [NUM_SECT-1:0] bits
);

  for (genvar g = 0; g < NUM_SECT; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rst_n)                                      bits[g] <= 1'b0;
      else if (clear)                                  bits[g] <= 1'b0;
      else if (set_en && (set_idx == SECT_W'(g)))      bits[g] <= 1'b1;
    end
  end

endmodule

// File: rtl/erase_window_timer.sv
module erase_window_timer
  import erase_seq_pkg::*;
#(
  parameter int WINDOW_CYC = 2500,
  localparam int CNT_W = (WINDOW_CYC > 1) ? $clog2(WINDOW_CYC) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             stop,
  output logic             expire,
  output logic [CNT_W-1:0] count
);

  logic running_q;

  assign expire = running_q && (count == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      running_q <= 1'b0;
      count     <= '0;
    end else if (stop) begin
      running_q <= 1'b0;
      count     <= '0;
    end else if (load) begin
      running_q <= 1'b1;
      count     <= CNT_W'(window_reload(WINDOW_CYC));
    end else if (expire) begin
      running_q <= 1'b0;
    end else if (running_q) begin
      count     <= count - 1'b1;
    end
  end

endmodule

// File: rtl/erase_seq_decoder.sv
module erase_seq_decoder
  import erase_seq_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int SECT_W     = 3,
  parameter int WINDOW_CYC = 2500,
  localparam int NUM_SECT  = 1 << SECT_W,
  localparam int CNT_W     = (WINDOW_CYC > 1) ? $clog2(WINDOW_CYC) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [ADDR_W-1:0]   wr_addr,
  input  logic [7:0]          wr_data,
  output logic                erase_start,
  output logic [NUM_SECT-1:0] erase_mask,
  output logic                timer_expired,
  output logic                read_mode
);

  dec_mode_t           mode_q;
  logic                in_window;
  logic                chip_hit;
  logic                sect_hit;
  logic [SECT_W-1:0]   sect_idx;
  logic                win_add;
  logic                win_abort;
  logic                win_expire;
  logic [NUM_SECT-1:0] queue_bits;
  logic [CNT_W-1:0]    tmr_count;

  assign in_window = (mode_q == MODE_WINDOW);

  // Window write classification; an expiring window takes no more writes.
  assign win_add   = in_window && wr_en && !win_expire && (wr_data == CODE_SECTOR);
  assign win_abort = in_window && wr_en && !win_expire &&
                     (wr_data != CODE_SECTOR) && (wr_data != CODE_PAUSE);

  erase_cycle_matcher #(
    .ADDR_W (ADDR_W),
    .SECT_W (SECT_W)
  ) matcher_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .hold     (in_window),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .chip_hit (chip_hit),
    .sect_hit (sect_hit),
    .sect_idx (sect_idx)
  );

  erase_sector_queue #(
    .NUM_SECT (NUM_SECT),
    .SECT_W   (SECT_W)
  ) queue_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_en  (sect_hit || win_add),
    .set_idx (sect_idx),
    .clear   (win_abort || win_expire),
    .bits    (queue_bits)
  );

  erase_window_timer #(
    .WINDOW_CYC (WINDOW_CYC)
  ) timer_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .load   (sect_hit || win_add),
    .stop   (win_abort),
    .expire (win_expire),
    .count  (tmr_count)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q        <= MODE_READ;
      erase_start   <= 1'b0;
      erase_mask    <= '0;
      timer_expired <= 1'b0;
    end else begin
      erase_start <= chip_hit || win_expire;
      if (chip_hit)        erase_mask <= '1;
      else if (win_expire) erase_mask <= queue_bits;

      if (chip_hit || win_expire) timer_expired <= 1'b1;
      else if (sect_hit)          timer_expired <= 1'b0;

      if (sect_hit)                     mode_q <= MODE_WINDOW;
      else if (win_abort || win_expire) mode_q <= MODE_READ;
    end
  end

  assign read_mode = !in_window;

endmodule

// File: rtl/erase_seq_checker.sv
module erase_seq_checker #(
  parameter int NUM_SECT   = 8,
  parameter int WINDOW_CYC = 2500,
  parameter int CNT_W      = 12
) (
  input logic                clk,
  input logic                rst_n,
  input logic                erase_start,
  input logic [NUM_SECT-1:0] erase_mask,
  input logic                timer_expired,
  input logic                read_mode,
  input logic                win_add,
  input logic                win_abort,
  input logic                win_expire,
  input logic [NUM_SECT-1:0] queue_bits,
  input logic [CNT_W-1:0]    tmr_count
);

  p_start_mask_nonzero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    erase_start |-> (erase_mask != '0));

  p_start_status_r4: assert property (@(posedge clk) disable iff (!rst_n)
    erase_start |-> (timer_expired && read_mode));

  p_expire_launch_r4: assert property (@(posedge clk) disable iff (!rst_n)
    win_expire |=> (erase_start && read_mode && (queue_bits == '0)));

  p_window_status_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !read_mode |-> !timer_expired);

  p_add_restarts_r5: assert property (@(posedge clk) disable iff (!rst_n)
    win_add |=> ((tmr_count == CNT_W'(WINDOW_CYC - 1)) && !read_mode));

  p_abort_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
    win_abort |=> (read_mode && (queue_bits == '0) && !erase_start));

  p_start_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
    erase_start |=> !erase_start);

  p_mask_held_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !erase_start |-> $stable(erase_mask));

  p_count_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
    tmr_count <= CNT_W'(WINDOW_CYC - 1));

endmodule

bind erase_seq_decoder erase_seq_checker #(
  .NUM_SECT   (NUM_SECT),
  .WINDOW_CYC (WINDOW_CYC),
  .CNT_W      (CNT_W)
) chk_i (
  .clk           (clk),
  .rst_n         (rst_n),
  .erase_start   (erase_start),
  .erase_mask    (erase_mask),
  .timer_expired (timer_expired),
  .read_mode     (read_mode),
  .win_add       (win_add),
  .win_abort     (win_abort),
  .win_expire    (win_expire),
  .queue_bits    (queue_bits),
  .tmr_count     (tmr_count)
);

// File: tb/erase_seq_decoder_tb_top.sv
module erase_seq_decoder_tb_top;

  localparam int ADDR_W = 16;
  localparam int SECT_W = 3;
  localparam int NS     = 1 << SECT_W;
  localparam int WIN    = 20;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              wr_en = 1'b0;
  logic [ADDR_W-1:0] wr_addr = '0;
  logic [7:0]        wr_data = '0;
  logic              erase_start;
  logic [NS-1:0]     erase_mask;
  logic              timer_expired;
  logic              read_mode;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #10ns clk = ~clk;

  erase_seq_decoder #(
    .ADDR_W     (ADDR_W),
    .SECT_W     (SECT_W),
    .WINDOW_CYC (WIN)
  ) dut_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .wr_en         (wr_en),
    .wr_addr       (wr_addr),
    .wr_data       (wr_data),
    .erase_start   (erase_start),
    .erase_mask    (erase_mask),
    .timer_expired (timer_expired),
    .read_mode     (read_mode)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] got, input logic [31:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, got, exp);
    end
  endtask

  // Called at a falling edge; the write is taken on the next rising edge.
  task automatic bus_write(input logic [ADDR_W-1:0] a, input logic [7:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic preamble();
    bus_write(16'h0555, 8'hAA);
    bus_write(16'h02AA, 8'h55);
    bus_write(16'h0555, 8'h80);
    bus_write(16'h0555, 8'hAA);
    bus_write(16'h02AA, 8'h55);
  endtask

  function automatic logic [ADDR_W-1:0] sect_addr(input int s);
    return ADDR_W'(s) << (ADDR_W - SECT_W);
  endfunction

  task automatic open_sector(input int s);
    preamble();
    bus_write(sect_addr(s) | 16'h0123, 8'h30);
  endtask

  // Counts falling edges until the start pulse is seen.
  task automatic cycles_to_start(output int n);
    n = 0;
    for (int i = 0; i < 4 * WIN; i++) begin
      @(negedge clk);
      n++;
      if (erase_start) break;
    end
    if (!erase_start) n = -1;
  endtask

  task automatic no_start_for(input string req, input int n);
    int seen = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (erase_start) seen++;
    end
    chk(req, "start pulses seen", seen, 0);
  endtask

  task automatic t_reset_state();
    chk("R1", "erase_start", erase_start, 0);
    chk("R1", "erase_mask", erase_mask, 0);
    chk("R1", "timer_expired", timer_expired, 0);
    chk("R1", "read_mode", read_mode, 1);
  endtask

  task automatic t_chip_erase();
    preamble();
    bus_write(16'h0555, 8'h10);
    chk("R2", "start after chip cmd", erase_start, 1);
    chk("R2", "chip mask", erase_mask, {NS{1'b1}});
    chk("R2", "status after chip", timer_expired, 1);
    chk("R2", "read_mode after chip", read_mode, 1);
    @(negedge clk);
    chk("R11", "start pulse width", erase_start, 0);
    chk("R11", "mask held", erase_mask, {NS{1'b1}});
  endtask

  task automatic t_single_sector();
    int n;
    open_sector(5);
    chk("R3", "window read_mode", read_mode, 0);
    chk("R3", "window status", timer_expired, 0);
    chk("R3", "no early start", erase_start, 0);
    cycles_to_start(n);
    chk("R4", "cycles to start", n, WIN);
    chk("R4", "single mask", erase_mask, 32'h20);
    chk("R4", "status after expiry", timer_expired, 1);
    chk("R4", "read_mode after expiry", read_mode, 1);
    idle(3);
    chk("R4", "status stays set", timer_expired, 1);
    chk("R11", "mask held later", erase_mask, 32'h20);
  endtask

  task automatic t_multi_sector();
    int n;
    open_sector(5);
    idle(10);
    bus_write(sect_addr(2), 8'h30);
    idle(4);
    bus_write(sect_addr(7) | 16'h0042, 8'h30);
    bus_write(sect_addr(2), 8'h30);
    cycles_to_start(n);
    chk("R5", "cycles after last add", n, WIN);
    chk("R5", "merged mask", erase_mask, 32'hA4);
  endtask

  task automatic t_pause_ignored();
    int n;
    open_sector(1);
    idle(5);
    bus_write(16'h0000, 8'hB0);
    chk("R6", "window still open", read_mode, 0);
    cycles_to_start(n);
    chk("R6", "window not restarted", n, WIN - 6);
    chk("R6", "mask unchanged", erase_mask, 32'h02);
  endtask

  task automatic t_abort();
    open_sector(3);
    idle(4);
    bus_write(16'h0000, 8'hF0);
    chk("R7", "read_mode after abort", read_mode, 1);
    chk("R7", "status after abort", timer_expired, 0);
    no_start_for("R7", WIN + 4);
    chk("R7", "mask untouched", erase_mask, 32'h02);
  endtask

  task automatic t_bad_preamble();
    int n;
    bus_write(16'h0555, 8'hAA);
    bus_write(16'h02AA, 8'h55);
    bus_write(16'h0555, 8'h81);
    bus_write(16'h0555, 8'hAA);
    bus_write(16'h02AA, 8'h55);
    bus_write(16'h0555, 8'h10);
    chk("R8", "bad setup no start", erase_start, 0);
    bus_write(16'h0554, 8'hAA);
    bus_write(16'h02AA, 8'h55);
    bus_write(16'h0555, 8'h80);
    bus_write(16'h0555, 8'hAA);
    bus_write(16'h02AA, 8'h55);
    bus_write(16'h0555, 8'h30);
    chk("R8", "bad unlock no window", read_mode, 1);
    no_start_for("R8", WIN + 2);
    open_sector(0);
    cycles_to_start(n);
    chk("R8", "clean sequence after errors", n, WIN);
    chk("R8", "mask after recovery", erase_mask, 32'h01);
  endtask

  task automatic t_edge_writes();
    int n;
    open_sector(4);
    idle(WIN - 2);
    bus_write(sect_addr(6), 8'h30);
    chk("R9", "last-cycle write keeps window", read_mode, 0);
    cycles_to_start(n);
    chk("R9", "last-cycle write accepted", n, WIN);
    chk("R9", "mask with last-cycle add", erase_mask, 32'h50);
    idle(2);
    open_sector(1);
    idle(WIN - 1);
    bus_write(sect_addr(3), 8'h30);
    chk("R9", "start on expiry edge", erase_start, 1);
    chk("R9", "late sector rejected", erase_mask, 32'h02);
    @(negedge clk);
    chk("R9", "no window after late write", read_mode, 1);
  endtask

  task automatic t_reset_in_window();
    open_sector(6);
    idle(3);
    rst_n = 1'b0;
    idle(2);
    rst_n = 1'b1;
    chk("R10", "read_mode after reset", read_mode, 1);
    chk("R10", "mask after reset", erase_mask, 0);
    chk("R10", "status after reset", timer_expired, 0);
    no_start_for("R10", WIN + 2);
  endtask

  initial begin
    idle(3);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset_state();
    t_chip_erase();
    t_single_sector();
    t_multi_sector();
    t_pause_ignored();
    t_abort();
    t_bad_preamble();
    t_edge_writes();
    t_reset_in_window();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    #(20ns * 100000);
    if (!done) begin
      done = 1'b1;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

endmodule